// File: doc/BRIEF.md
# Saturating Add/Subtract Unit with Condition Flags

This block is a registered integer unit that either adds two operands or subtracts the first from the second. It clamps the result to the largest or smallest signed value whenever the signed result would not fit. Alongside the result it reports four condition flags: zero, sign, carry and overflow. It also keeps a sticky saturation flag that records every clamp since the last time software cleared it.

An operation is taken on a clock edge where `in_valid` is high. The result and the four condition flags then hold until the next valid operation. The zero, carry and overflow flags describe the wrapped (modular) result. The sign flag and the data output describe the value that is actually delivered, so they follow the clamp. The sticky flag is cleared only by reset or by `sat_clr`. If a saturating operation and a clear arrive in the same cycle, the saturating operation wins.

Top module: `satarith_unit`

## Requirements
- R1: With `op_sel` = 0 (add) and no signed overflow, `res` becomes `opa + opb` modulo 2^WIDTH on the valid edge.
- R2: With `op_sel` = 1 (subtract) and no signed overflow, `res` becomes `opb - opa` modulo 2^WIDTH on the valid edge.
- R3: `flag_cy` is the unsigned carry out of the addition. For subtraction it is set exactly when `opb` is less than `opa` as unsigned numbers.
- R4: `flag_ov` is set on an add when both operands have the same sign bit and the wrapped sum has the other sign. It is set on a subtract when the operand sign bits differ and the wrapped difference's sign bit differs from that of `opb`.
- R5: When `flag_ov` is set, `res` is 2^(WIDTH-1)-1 with `flag_s` = 0 if the wrapped result is negative. Otherwise `res` is 2^(WIDTH-1) with `flag_s` = 1.
- R6: `flag_z` is set exactly when the wrapped result is zero, even when the delivered result is clamped.
- R7: Without overflow, `flag_s` equals the most significant bit of `res`.
- R8: On a cycle with `in_valid` low, `res`, `flag_z`, `flag_s`, `flag_cy` and `flag_ov` keep their values.
- R9: `flag_sat` is set by every valid operation that overflows. It stays set across later operations until `sat_clr` is high on an edge without a new overflow. A same-cycle overflow takes priority over the clear.
- R10: A synchronous active-high `rst` clears `res` and all five flags on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Take an operation on this edge |
| op_sel | input | 1 | 0 = add, 1 = subtract (opb - opa) |
| sat_clr | input | 1 | Clear the sticky saturation flag |
| opa | input | WIDTH | First operand (subtrahend for subtract) |
| opb | input | WIDTH | Second operand (minuend for subtract) |
| res | output | WIDTH | Registered, possibly clamped result |
| flag_z | output | 1 | Wrapped result is zero |
| flag_s | output | 1 | Sign of the delivered result |
| flag_cy | output | 1 | Carry out (add) or borrow (subtract) |
| flag_ov | output | 1 | Signed overflow of the wrapped result |
| flag_sat | output | 1 | Sticky saturation flag |

## Verification
Directed vectors come first. They cover positive and negative overflow for both operations, the add of two minimum values (wrapped zero, so zero and overflow are set together and the output is the negative clamp), borrow without overflow, and carry without overflow. These separate the wrapped-result flags from the clamped output and sign. Idle cycles, clears with and without a coincident overflow, and a mid-run reset test holding, stickiness and clear priority. A long random run with a biased mix of extreme operands then compares every output against a behavioural model on each cycle.

// File: rtl/satarith_pkg.sv
package satarith_pkg;

    localparam int unsigned DATA_W = 32;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    typedef struct packed {
        logic z;
        logic s;
        logic cy;
        logic ov;
    } ccode_t;

    localparam ccode_t CCODE_CLEAR = '{z: 1'b0, s: 1'b0, cy: 1'b0, ov: 1'b0};

endpackage

// File: rtl/satarith_core.sv
module satarith_core
    import satarith_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] wrapped,
    output logic             carry
);
    localparam int unsigned EXT_W = WIDTH + 1;

    logic [WIDTH-1:0] lhs;
    logic [WIDTH-1:0] rhs;
    logic             cin;
    logic [EXT_W-1:0] total;

    // Subtract is done as opb + ~opa + 1; the adder carry is then the inverse of borrow.
    always_comb begin
        lhs = opb;
        rhs = (op == OP_SUB) ? ~opa : opa;
        cin = (op == OP_SUB);
        total = {1'b0, lhs} + {1'b0, rhs} + {{WIDTH{1'b0}}, cin};
        wrapped = total[WIDTH-1:0];
        carry   = total[WIDTH] ^ cin;
    end

endmodule

// File: rtl/satarith_clamp.sv
module satarith_clamp
    import satarith_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [WIDTH-1:0] wrapped,
    input  logic             carry,
    output logic [WIDTH-1:0] result,
    output ccode_t           cc
);
    localparam int unsigned MSB = WIDTH - 1;
    localparam logic [WIDTH-1:0] POS_LIMIT = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] NEG_LIMIT = {1'b1, {(WIDTH-1){1'b0}}};

    logic sa;
    logic sb;
    logic sr;
    logic ovf;

    always_comb begin
        sa = opa[MSB];
        sb = opb[MSB];
        sr = wrapped[MSB];
        unique case (op)
            OP_ADD:  ovf = (sa == sb) && (sr != sa);
            OP_SUB:  ovf = (sa != sb) && (sr != sb);
            default: ovf = 1'b0;
        endcase

        cc.z  = (wrapped == '0);
        cc.cy = carry;
        cc.ov = ovf;
        if (ovf) begin
            result = sr ? POS_LIMIT : NEG_LIMIT;
            cc.s   = ~sr;
        end else begin
            result = wrapped;
            cc.s   = sr;
        end
    end

endmodule

// File: rtl/satarith_state.sv
module satarith_state
    import satarith_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             sat_clr,
    input  logic [WIDTH-1:0] result_d,
    input  ccode_t           cc_d,
    output logic [WIDTH-1:0] result_q,
    output ccode_t           cc_q,
    output logic             sat_q
);
    logic sat_set;

    always_comb sat_set = load && cc_d.ov;

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            cc_q     <= CCODE_CLEAR;
        end else if (load) begin
            result_q <= result_d;
            cc_q     <= cc_d;
        end
    end

    // A new saturation has priority over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            sat_q <= 1'b0;
        end else if (sat_set) begin
            sat_q <= 1'b1;
        end else if (sat_clr) begin
            sat_q <= 1'b0;
        end
    end

endmodule

// File: rtl/satarith_unit.sv
module satarith_unit
    import satarith_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             op_sel,
    input  logic             sat_clr,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] res,
    output logic             flag_z,
    output logic             flag_s,
    output logic             flag_cy,
    output logic             flag_ov,
    output logic             flag_sat
);
    op_e              op;
    logic [WIDTH-1:0] wrapped;
    logic             carry;
    logic [WIDTH-1:0] result_d;
    ccode_t           cc_d;
    ccode_t           cc_q;

    assign op = op_e'(op_sel);

    satarith_core #(.WIDTH(WIDTH)) u_core (
        .op      (op),
        .opa     (opa),
        .opb     (opb),
        .wrapped (wrapped),
        .carry   (carry)
    );

    satarith_clamp #(.WIDTH(WIDTH)) u_clamp (
        .op      (op),
        .opa     (opa),
        .opb     (opb),
        .wrapped (wrapped),
        .carry   (carry),
        .result  (result_d),
        .cc      (cc_d)
    );

    satarith_state #(.WIDTH(WIDTH)) u_state (
        .clk      (clk),
        .rst      (rst),
        .load     (in_valid),
        .sat_clr  (sat_clr),
        .result_d (result_d),
        .cc_d     (cc_d),
        .result_q (res),
        .cc_q     (cc_q),
        .sat_q    (flag_sat)
    );

    assign flag_z  = cc_q.z;
    assign flag_s  = cc_q.s;
    assign flag_cy = cc_q.cy;
    assign flag_ov = cc_q.ov;

endmodule

// File: rtl/satarith_chk.sv
module satarith_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             sat_clr,
    input logic [WIDTH-1:0] res,
    input logic             flag_z,
    input logic             flag_s,
    input logic             flag_cy,
    input logic             flag_ov,
    input logic             flag_sat
);
    localparam logic [WIDTH-1:0] POS_LIMIT = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] NEG_LIMIT = {1'b1, {(WIDTH-1){1'b0}}};

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (res == '0 && !flag_z && !flag_s && !flag_cy && !flag_ov && !flag_sat)); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res) && $stable(flag_z) && $stable(flag_s)
                       && $stable(flag_cy) && $stable(flag_ov))); // R8

    AST_CLAMP_VALUE: assert property (@(posedge clk) disable iff (rst)
        flag_ov |-> ((res == POS_LIMIT && !flag_s) || (res == NEG_LIMIT && flag_s))); // R5

    AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (rst)
        !flag_ov |-> (flag_s == res[WIDTH-1])); // R7

    AST_Z_UNCLAMPED: assert property (@(posedge clk) disable iff (rst)
        (flag_z && !flag_ov) |-> (res == '0)); // R6

    AST_OV_SETS_SAT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!flag_ov || flag_sat)); // R9

    AST_SAT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_sat && !sat_clr) |=> flag_sat); // R9

    AST_SAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (sat_clr && !in_valid) |=> !flag_sat); // R9

endmodule

bind satarith_unit satarith_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .sat_clr  (sat_clr),
    .res      (res),
    .flag_z   (flag_z),
    .flag_s   (flag_s),
    .flag_cy  (flag_cy),
    .flag_ov  (flag_ov),
    .flag_sat (flag_sat)
);

// File: tb/satarith_unit_tb.sv
module satarith_unit_tb;
    localparam int W = 32;
    localparam int WATCHDOG_CYC = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         op_sel = 1'b0;
    logic         sat_clr = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] res;
    logic         flag_z, flag_s, flag_cy, flag_ov, flag_sat;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state
    logic [W-1:0] m_res = '0;
    logic m_z = 0, m_s = 0, m_cy = 0, m_ov = 0, m_sat = 0;
    string ctx = "R10";

    always #2.5 clk = ~clk;

    satarith_unit #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .sat_clr(sat_clr), .opa(opa), .opb(opb), .res(res),
        .flag_z(flag_z), .flag_s(flag_s), .flag_cy(flag_cy),
        .flag_ov(flag_ov), .flag_sat(flag_sat)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string r_res = (ctx == "") ? (op_sel ? "R2/R5" : "R1/R5") : ctx;
        chk({r_res, " res"}, res, m_res);
        chk((ctx == "") ? "R6 z" : {ctx, " z"}, {31'd0, flag_z}, {31'd0, m_z});
        chk((ctx == "") ? "R7/R5 s" : {ctx, " s"}, {31'd0, flag_s}, {31'd0, m_s});
        chk((ctx == "") ? "R3 cy" : {ctx, " cy"}, {31'd0, flag_cy}, {31'd0, m_cy});
        chk((ctx == "") ? "R4 ov" : {ctx, " ov"}, {31'd0, flag_ov}, {31'd0, m_ov});
        chk("R9 sat", {31'd0, flag_sat}, {31'd0, m_sat});
    endtask

    // Behavioural next-state of the model for the inputs now applied.
    task automatic model_step();
        longint unsigned ua, ub, full;
        logic [W-1:0] w;
        logic neg, ov, cy;
        ua = longint'(opa);
        ub = longint'(opb);
        if (rst) begin
            m_res = '0; m_z = 0; m_s = 0; m_cy = 0; m_ov = 0; m_sat = 0;
            ctx = "R10";
            return;
        end
        if (!in_valid) begin
            if (sat_clr) m_sat = 0;
            ctx = "R8";
            return;
        end
        ctx = "";
        if (!op_sel) begin
            full = ua + ub;
            cy = full >= 64'h1_0000_0000;
            w = full[W-1:0];
            ov = (opa[W-1] == opb[W-1]) && (w[W-1] != opa[W-1]);
        end else begin
            full = ub - ua;
            cy = ub < ua;
            w = full[W-1:0];
            ov = (opa[W-1] != opb[W-1]) && (w[W-1] != opb[W-1]);
        end
        neg = w[W-1];
        m_z = (w == 0);
        m_cy = cy;
        m_ov = ov;
        if (ov) begin
            m_res = neg ? 32'h7FFF_FFFF : 32'h8000_0000;
            m_s = !neg;
            m_sat = 1;
        end else begin
            m_res = w;
            m_s = neg;
            if (sat_clr) m_sat = 0;
        end
    endtask

    task automatic step(input logic r, input logic v, input logic op, input logic clr,
                        input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        compare_all();
        rst = r; in_valid = v; op_sel = op; sat_clr = clr; opa = a; opb = b;
        model_step();
    endtask

    function automatic logic [W-1:0] pick();
        case ($urandom_range(0, 5))
            0: return 32'h7FFF_FFFF;
            1: return 32'h8000_0000;
            2: return 32'h0000_0000;
            3: return 32'hFFFF_FFFF;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        step(0, 1, 0, 0, 32'd5, 32'd7);                 // R1 plain add
        step(0, 1, 1, 0, 32'd5, 32'd7);                 // R2 7-5
        step(0, 1, 1, 0, 32'd9, 32'd3);                 // R3 borrow, no ov
        step(0, 1, 0, 0, 32'hFFFF_FFFF, 32'd1);          // R3 carry, R6 zero
        step(0, 1, 0, 0, 32'h7FFF_FFFF, 32'd1);          // R5 positive overflow
        step(0, 0, 0, 0, 32'd1, 32'd1);                  // R8 idle hold
        step(0, 1, 0, 0, 32'd1, 32'd2);                  // R9 sat sticky
        step(0, 1, 0, 0, 32'h8000_0000, 32'h8000_0000);  // R6 wrapped zero with ov
        step(0, 1, 1, 0, 32'd1, 32'h8000_0000);          // R4 sub negative overflow
        step(0, 1, 1, 0, 32'h8000_0000, 32'd0);          // R4 0 - min
        step(0, 0, 0, 1, 0, 0);                          // R9 clear
        step(0, 1, 0, 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);  // R9 ov beats clear
        step(0, 1, 1, 1, 32'd2, 32'd2);                  // R9 clear with valid, no ov
        step(0, 1, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF);  // R5 neg overflow
        step(1, 0, 0, 0, 0, 0);                          // R10 mid-run reset
        step(0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4000; i++) begin
            step(($urandom_range(0, 199) == 0), ($urandom_range(0, 3) != 0),
                 $urandom_range(0, 1), ($urandom_range(0, 7) == 0), pick(), pick());
        end
        step(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare_all();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule